// File: doc/BRIEF.md
# Configurable Serial Receive Deserializer

This block collects bits from one serial data line into a 24-bit word and hands each finished word to a holding register that software or a neighbouring block reads. A bit is taken only on a cycle where the bit-clock enable is high and frame sync is asserted. The word length is selected from five values. The bit order can be most-significant first or least-significant first.

A finished word is placed in the holding register in one of two alignments. In the wide alignment its top bit lands at bit 23. In the narrow alignment its top bit lands at bit 15. Every position the word does not fill reads as zero. Loading the register raises a full flag and, when enabled, a one-cycle interrupt pulse. A read strobe clears the flag. A word that lands on an unread one sets an overrun flag. If frame sync drops before a word is finished, the partial word is discarded.

Top module: `serial_rx_deser`

## Requirements
- R1: A bit is accepted only on a clock where `bit_en` and `frame_sync` are both 1. Cycles with `bit_en` low neither count nor shift, whatever `sdata` carries.
- R2: `wlen_code` selects the number of bit times per word: 0 selects 8, 1 selects 12, 2 selects 16, 3 selects 24, 4 selects 32, and codes 5 to 7 select 24. The holding register loads on the same clock edge that accepts the last bit of the word.
- R3: With `lsb_first` at 0 the first bit received is the word's most significant bit. With `lsb_first` at 1 the first bit received is bit 0.
- R4: In the 32 bit-time mode only the first 24 bits received are kept as the word (bit order per R3). The last 8 bit times are counted and their data is discarded.
- R5: With `align_low` at 0 the word's MSB sits at `rx_data[23]`. With `align_low` at 1 it sits at `rx_data[15]`, `rx_data[23:16]` are zero, and a 24-bit word loses its lowest 8 bits. Unfilled low positions are zero in both cases.
- R6: `rx_data` changes only when a word completes. On completion `rx_full` is set.
- R7: When `irq_en` is 1 at completion, `rx_irq` is high for exactly the one cycle after the load edge. It stays low otherwise.
- R8: `rd_strobe` clears `rx_full` and `rx_overrun`. A completion while `rx_full` is 1 and `rd_strobe` is 0 sets `rx_overrun`, and the new word replaces the old one. A completion together with `rd_strobe` leaves `rx_full` at 1 and `rx_overrun` at 0.
- R9: `bit_en` high with `frame_sync` low resets the bit count and drops any partial word. The next word starts from its first bit.
- R10: After synchronous reset, `rx_data` is zero and `rx_full`, `rx_overrun` and `rx_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable, one pulse per serial bit |
| frame_sync | input | 1 | Frame active; bits are taken only while high |
| sdata | input | 1 | Serial data in |
| wlen_code | input | 3 | Word length select |
| lsb_first | input | 1 | Bit order: 0 MSB first, 1 LSB first |
| align_low | input | 1 | Alignment: 0 MSB at bit 23, 1 MSB at bit 15 |
| irq_en | input | 1 | Interrupt enable |
| rd_strobe | input | 1 | Read acknowledge; clears full and overrun |
| rx_data | output | 24 | Aligned received word |
| rx_full | output | 1 | Holding register holds an unread word |
| rx_overrun | output | 1 | A word arrived before the previous one was read |
| rx_irq | output | 1 | One-cycle interrupt pulse on load |

## Verification
The assertions assume that `wlen_code`, `lsb_first` and `align_low` are held stable from the first bit of a word to its last. They also assume that bit pulses are spaced so that two completions never fall on adjacent clocks. The stimulus changes configuration only while frame sync is low and no word is partly received. The shortest word is 8 pulses, so completions always fall at least 8 clocks apart. The reference model accepts any `sdata` in idle cycles, and the bench fills those cycles with random values to show that they are ignored.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int DATA_W  = 24;
    localparam int MAX_WL  = 32;
    localparam int CNT_W   = $clog2(MAX_WL);
    localparam int LEN_W   = $clog2(MAX_WL) + 1;
    localparam int NARROW_SHIFT = 8;

    typedef enum logic [2:0] {
        WL_8  = 3'd0,
        WL_12 = 3'd1,
        WL_16 = 3'd2,
        WL_24 = 3'd3,
        WL_32 = 3'd4
    } wlen_e;

    typedef struct packed {
        logic             lsb_first;
        logic             align_low;
        logic [LEN_W-1:0] word_bits;
        logic [LEN_W-1:0] data_bits;
    } rx_cfg_t;

    typedef struct packed {
        logic full;
        logic overrun;
        logic irq;
    } rx_stat_t;

    function automatic logic [LEN_W-1:0] word_bits_of(input logic [2:0] code);
        logic [LEN_W-1:0] r;
        case (code)
            WL_8:    r = LEN_W'(8);
            WL_12:   r = LEN_W'(12);
            WL_16:   r = LEN_W'(16);
            WL_32:   r = LEN_W'(32);
            default: r = LEN_W'(24);
        endcase
        return r;
    endfunction

    function automatic logic [LEN_W-1:0] data_bits_of(input logic [LEN_W-1:0] wb);
        return (int'(wb) > DATA_W) ? LEN_W'(DATA_W) : wb;
    endfunction

endpackage

// File: rtl/srx_bit_counter.sv
module srx_bit_counter
    import srx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             frame_sync,
    input  logic [LEN_W-1:0] word_bits,
    output logic [CNT_W-1:0] bit_cnt,
    output logic             accept,
    output logic             abort,
    output logic             word_done
);

    logic [LEN_W-1:0] cnt_ext;

    assign accept    = bit_en & frame_sync;
    assign abort     = bit_en & ~frame_sync;
    assign cnt_ext   = {1'b0, bit_cnt};
    assign word_done = accept & (cnt_ext >= word_bits - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
        end else if (abort || word_done) begin
            bit_cnt <= '0;
        end else if (accept) begin
            bit_cnt <= bit_cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/srx_shift_assembler.sv
module srx_shift_assembler
    import srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              abort,
    input  logic              word_done,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic              lsb_first,
    input  logic              sdata,
    output logic [DATA_W-1:0] word_next
);

    logic [DATA_W-1:0] sr;
    logic              keep;

    assign keep = accept & (int'(bit_cnt) < DATA_W);

    always_comb begin
        word_next = sr;
        if (keep) begin
            if (lsb_first) begin
                for (int i = 0; i < DATA_W; i++) begin
                    if (int'(bit_cnt) == i) word_next[i] = sdata;
                end
            end else begin
                word_next = {sr[DATA_W-2:0], sdata};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || abort || word_done) begin
            sr <= '0;
        end else if (keep) begin
            sr <= word_next;
        end
    end

endmodule

// File: rtl/srx_align.sv
module srx_align
    import srx_pkg::*;
(
    input  logic [DATA_W-1:0] word_in,
    input  logic [LEN_W-1:0]  data_bits,
    input  logic              align_low,
    output logic [DATA_W-1:0] word_out
);

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] wide;

    always_comb begin
        mask     = {DATA_W{1'b1}} >> (DATA_W - int'(data_bits));
        wide     = (word_in & mask) << (DATA_W - int'(data_bits));
        word_out = align_low ? (wide >> NARROW_SHIFT) : wide;
    end

endmodule

// File: rtl/srx_hold_reg.sv
module srx_hold_reg
    import srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_strobe,
    input  logic              irq_en,
    output logic [DATA_W-1:0] dout,
    output rx_stat_t          stat
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
            stat <= '0;
        end else begin
            stat.irq <= load & irq_en;
            if (load) dout <= din;
            if (load)           stat.full <= 1'b1;
            else if (rd_strobe) stat.full <= 1'b0;
            if (rd_strobe)              stat.overrun <= 1'b0;
            else if (load && stat.full) stat.overrun <= 1'b1;
        end
    end

endmodule

// File: rtl/serial_rx_deser.sv
module serial_rx_deser
    import srx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bit_en,
    input  logic        frame_sync,
    input  logic        sdata,
    input  logic [2:0]  wlen_code,
    input  logic        lsb_first,
    input  logic        align_low,
    input  logic        irq_en,
    input  logic        rd_strobe,
    output logic [23:0] rx_data,
    output logic        rx_full,
    output logic        rx_overrun,
    output logic        rx_irq
);

    rx_cfg_t           cfg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              accept, abort, word_done;
    logic [DATA_W-1:0] word_next, word_aligned;
    rx_stat_t          stat;

    always_comb begin
        cfg.lsb_first = lsb_first;
        cfg.align_low = align_low;
        cfg.word_bits = word_bits_of(wlen_code);
        cfg.data_bits = data_bits_of(cfg.word_bits);
    end

    srx_bit_counter u_cnt (
        .clk(clk), .rst(rst), .bit_en(bit_en), .frame_sync(frame_sync),
        .word_bits(cfg.word_bits), .bit_cnt(bit_cnt), .accept(accept),
        .abort(abort), .word_done(word_done)
    );

    srx_shift_assembler u_asm (
        .clk(clk), .rst(rst), .accept(accept), .abort(abort),
        .word_done(word_done), .bit_cnt(bit_cnt), .lsb_first(cfg.lsb_first),
        .sdata(sdata), .word_next(word_next)
    );

    srx_align u_align (
        .word_in(word_next), .data_bits(cfg.data_bits),
        .align_low(cfg.align_low), .word_out(word_aligned)
    );

    srx_hold_reg u_hold (
        .clk(clk), .rst(rst), .load(word_done), .din(word_aligned),
        .rd_strobe(rd_strobe), .irq_en(irq_en), .dout(rx_data), .stat(stat)
    );

    assign rx_full    = stat.full;
    assign rx_overrun = stat.overrun;
    assign rx_irq     = stat.irq;

endmodule

// File: rtl/srx_checker.sv
module srx_checker (
    input logic        clk,
    input logic        rst,
    input logic        bit_en,
    input logic        frame_sync,
    input logic        align_low,
    input logic        irq_en,
    input logic        rd_strobe,
    input logic        word_done,
    input logic [4:0]  bit_cnt,
    input logic [23:0] rx_data,
    input logic        rx_full,
    input logic        rx_overrun,
    input logic        rx_irq
);

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !word_done |=> $stable(rx_data)); // R6

    AST_FULL_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        word_done |=> rx_full); // R6

    AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (word_done && align_low) |=> (rx_data[23:16] == 8'h00)); // R5

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        (word_done && !irq_en) |=> !rx_irq); // R7

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rx_irq |=> !rx_irq); // R7

    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_overrun) |-> $past(rx_full) && $past(word_done)); // R8

    AST_READ_CLEARS_OVR: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |=> !rx_overrun); // R8

    AST_ABORT_RESETS: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !frame_sync) |=> (bit_cnt == 5'd0)); // R9

    AST_IDLE_HOLDS_CNT: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(bit_cnt)); // R1

endmodule

bind serial_rx_deser srx_checker u_chk (
    .clk(clk), .rst(rst), .bit_en(bit_en), .frame_sync(frame_sync),
    .align_low(align_low), .irq_en(irq_en), .rd_strobe(rd_strobe),
    .word_done(word_done), .bit_cnt(bit_cnt), .rx_data(rx_data),
    .rx_full(rx_full), .rx_overrun(rx_overrun), .rx_irq(rx_irq)
);

// File: tb/tb_serial_rx_deser.sv
`timescale 1ns/1ps
module tb_serial_rx_deser;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst, bit_en, frame_sync, sdata, lsb_first, align_low, irq_en, rd_strobe;
    logic [2:0]  wlen_code;
    logic [23:0] rx_data;
    logic        rx_full, rx_overrun, rx_irq;

    serial_rx_deser dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .frame_sync(frame_sync),
        .sdata(sdata), .wlen_code(wlen_code), .lsb_first(lsb_first),
        .align_low(align_low), .irq_en(irq_en), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .rx_full(rx_full), .rx_overrun(rx_overrun),
        .rx_irq(rx_irq)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    chk_on  = 0;
    string tag     = "R2";

    // behavioural reference model
    int          q[$];
    logic [23:0] m_data;
    logic        m_full, m_ov, m_irq;

    function automatic int wl_of(input logic [2:0] c);
        case (c)
            3'd0: return 8;
            3'd1: return 12;
            3'd2: return 16;
            3'd4: return 32;
            default: return 24;
        endcase
    endfunction

    function automatic logic [23:0] build(input bit lsb, input bit al, input int wl);
        int          n;
        logic [31:0] w;
        logic [31:0] o;
        n = (wl > 24) ? 24 : wl;
        w = 0;
        for (int i = 0; i < n; i++) begin
            if (lsb) w[i] = q[i][0];
            else     w[n-1-i] = q[i][0];
        end
        o = (w << (24 - n)) & 32'h00FF_FFFF;
        if (al) o = o >> 8;
        return o[23:0];
    endfunction

    always @(posedge clk) begin
        bit ld;
        ld = 0;
        if (rst) begin
            q.delete();
            m_data = 0; m_full = 0; m_ov = 0; m_irq = 0;
        end else begin
            if (bit_en) begin
                if (frame_sync) begin
                    q.push_back(int'(sdata));
                    if (q.size() == wl_of(wlen_code)) begin
                        ld = 1;
                        m_data = build(lsb_first, align_low, wl_of(wlen_code));
                        q.delete();
                    end
                end else begin
                    q.delete();
                end
            end
            m_irq = ld && irq_en;
            if (rd_strobe) m_ov = 0;
            else if (ld && m_full) m_ov = 1;
            if (ld) m_full = 1;
            else if (rd_strobe) m_full = 0;
        end
    end

    task automatic chk(input string r, input logic [23:0] act, input logic [23:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%h expected=%h", r, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            chk(tag,  rx_data, m_data);
            chk("R6", {23'd0, rx_full}, {23'd0, m_full});
            chk("R8", {23'd0, rx_overrun}, {23'd0, m_ov});
            chk("R7", {23'd0, rx_irq}, {23'd0, m_irq});
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send_word(input int nbits, input logic [31:0] pat, input int gap);
        for (int i = 0; i < nbits; i++) begin
            frame_sync = 1; bit_en = 1; sdata = pat[nbits-1-i];
            tick();
            bit_en = 0;
            for (int g = 0; g < gap; g++) begin
                sdata = $urandom_range(0, 1);
                tick();
            end
        end
    endtask

    task automatic do_read();
        rd_strobe = 1; tick(); rd_strobe = 0;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1; bit_en = 0; frame_sync = 0; sdata = 0; wlen_code = 0;
        lsb_first = 0; align_low = 0; irq_en = 1; rd_strobe = 0;
        repeat (3) tick();
        // R10 reset state
        chk("R10", rx_data, 24'h0);
        chk("R10", {21'd0, rx_full, rx_overrun, rx_irq}, 24'h0);
        rst = 0;
        chk_on = 1;

        // R2 R3 R5 R4: every length, order and alignment
        for (int c = 0; c < 5; c++) begin
            for (int l = 0; l < 2; l++) begin
                for (int a = 0; a < 2; a++) begin
                    wlen_code = 3'(c); lsb_first = l[0]; align_low = a[0];
                    tag = (c == 4) ? "R4" : (a == 1) ? "R5" : (l == 1) ? "R3" : "R2";
                    send_word(wl_of(3'(c)), $urandom, c % 2);
                    frame_sync = 0; tick(); tick();
                    do_read(); tick();
                end
            end
        end

        // R3 fixed pattern, both orders
        tag = "R3"; wlen_code = 3'd0; align_low = 0;
        lsb_first = 0; send_word(8, 32'h01, 0); frame_sync = 0; tick(); do_read();
        lsb_first = 1; send_word(8, 32'h01, 0); frame_sync = 0; tick(); do_read();

        // R2 reserved codes act as 24
        tag = "R2"; lsb_first = 0;
        for (int c = 5; c < 8; c++) begin
            wlen_code = 3'(c);
            send_word(24, $urandom, 0); frame_sync = 0; tick(); do_read();
        end

        // R1 long idle gaps with toggling data
        tag = "R1"; wlen_code = 3'd2;
        send_word(16, $urandom, 3); frame_sync = 0; tick(); do_read();

        // R9 partial word dropped
        tag = "R9"; wlen_code = 3'd1;
        send_word(5, 32'h1F, 0);
        frame_sync = 0; bit_en = 1; tick(); bit_en = 0; tick();
        send_word(12, $urandom, 1); frame_sync = 0; tick(); do_read();

        // R8 overrun, then read clears
        tag = "R8"; wlen_code = 3'd0;
        send_word(8, $urandom, 0); send_word(8, $urandom, 0);
        frame_sync = 0; tick(); tick(); do_read(); tick();
        // R8 read on the same cycle as load
        send_word(8, $urandom, 0);
        send_word(7, $urandom, 0);
        frame_sync = 1; bit_en = 1; rd_strobe = 1; sdata = 1; tick();
        bit_en = 0; rd_strobe = 0; frame_sync = 0; tick(); tick(); do_read();

        // R7 interrupt disabled
        tag = "R7"; irq_en = 0; wlen_code = 3'd3;
        send_word(24, $urandom, 0); frame_sync = 0; tick(); do_read();
        irq_en = 1;

        // R6 back-to-back words in one frame
        tag = "R6"; wlen_code = 3'd4; lsb_first = 1; align_low = 1;
        for (int k = 0; k < 3; k++) begin
            send_word(32, $urandom, 0); do_read();
        end
        frame_sync = 0; repeat (4) tick();

        chk_on = 0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule